// File: doc/BRIEF.md
# Six-Source Vectored Interrupt Controller

This block collects interrupt events from six sources and presents one of them at a time to a CPU. Three external pins are treated as edge inputs. A falling edge on each pin raises its own request, and the first pin also raises a separate request on its rising edge. Two internal timer pulses fill the remaining request lines. Each event sets a bit in a request register. That bit stays set until the CPU is granted that interrupt or software clears the bit. Software can read the request register at any time, so a polled system can keep every interrupt masked and still find out which sources need service.

A mask register holds one enable bit per source and a global enable bit. A request is armed only when its own enable and the global enable are both set. When several armed requests are pending, a 3-bit priority register picks a rotated order that decides the winner. The controller holds a level `irqPending` output while any request is armed. It shows the winner's vector-table address at all times. When the CPU pulses `grant`, the controller clears the winning request bit and the global enable on that clock edge. This blocks further interrupts until software sets the global enable again.

Top module: `irqvc_top`

## Requirements
- R1: After reset the request register, the mask register (global and individual enables) and the priority register all read 0, and `irqPending` is 0.
- R2: The external pins pass through a two-flop synchronizer. The sources map as follows:
  - Request bit 0: falling edge on `pinA`.
  - Request bit 1: falling edge on `pinB`.
  - Request bit 2: falling edge on `pinC`.
  - Request bit 3: rising edge on `pinA`.
  - Request bit 4: a high cycle on `tmr0Pulse`.
  - Request bit 5: a high cycle on `tmr1Pulse`.

  A pin change driven before clock edge k is visible in the request register after edge k+2. A timer pulse is visible after the edge that samples it.
- R3: A set request bit holds until a grant clears it or software writes a 0 to it. Writing a 1 to a request bit leaves it unchanged.
- R4: The request register latches events and reads back correctly while all enables are 0.
- R5: The register map is as follows. Unused addresses read 0.
  - Address 0: request bits in bits 5:0.
  - Address 1: the mask. The global enable is bit 7 and the per-source enables are bits 5:0. Bit 6 reads 0.
  - Address 2: the priority in bits 2:0.
- R6: `irqPending` is 1 exactly when the global enable is set and at least one request bit has its own enable set.
- R7: A priority value p from 0 to 5 gives request p the highest priority, then p+1, and so on, wrapping after 5. Values 6 and 7 act as 0.
- R8: While `irqPending` is 1, `vectorAddr` equals 2n, where n is the winning request. It is 0 when nothing is pending.
- R9: A `grant` cycle with `irqPending` high clears the winning request bit and the global enable at that edge. A `grant` with nothing pending changes no state.
- R10: If a new event for the winning source arrives in the same cycle that a grant clears it, the request bit stays set.
- R11: A pin held at a constant level raises no further requests after its bit is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pinA | input | 1 | External pin, falling edge to bit 0 and rising edge to bit 3 |
| pinB | input | 1 | External pin, falling edge to bit 1 |
| pinC | input | 1 | External pin, falling edge to bit 2 |
| tmr0Pulse | input | 1 | Timer 0 event pulse, to bit 4 |
| tmr1Pulse | input | 1 | Timer 1 event pulse, to bit 5 |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data, combinational from `regAddr` |
| grant | input | 1 | One-cycle interrupt acknowledge from the CPU |
| irqPending | output | 1 | An armed request exists |
| vectorAddr | output | 4 | Vector table byte address of the winner |

## Verification
A stale or corrupt request bit shows up within one read at address 0. It also changes `irqPending` and `vectorAddr` in the same cycle, because both outputs are combinational from the stored state. A wrong priority rotation or winner index shows up immediately on `vectorAddr` as soon as the priority register is written. A grant that fails to clear the global enable or the winning bit shows up in the next cycle, either as `irqPending` staying high or in the next read of the mask and request registers. Synchronizer or edge-detector faults show up as a request bit appearing a cycle early or late relative to the pin change, or as a bit coming back after being cleared while a pin is held low.

// File: rtl/irqvc_pkg.sv
package irqvc_pkg;
  localparam int NUM_SRC  = 6;
  localparam int NUM_PINS = 3;
  localparam int IDX_W    = $clog2(NUM_SRC);
  localparam int VEC_W    = IDX_W + 1;
  localparam int PRIO_W   = 3;
  localparam int DATA_W   = 8;
  localparam int ADDR_W   = 2;

  localparam logic [ADDR_W-1:0] ADDR_REQ  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_MASK = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_PRIO = 2'd2;

  // strobes from control to datapath
  typedef struct packed {
    logic [NUM_SRC-1:0] clrReq;
    logic               clrGlobal;
  } ctrl_strobe_t;
endpackage

// File: rtl/irqvc_datapath.sv
module irqvc_datapath
  import irqvc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                pinA,
  input  logic                pinB,
  input  logic                pinC,
  input  logic                tmr0Pulse,
  input  logic                tmr1Pulse,
  input  logic                regWrEn,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [DATA_W-1:0]   regWrData,
  input  ctrl_strobe_t        strobes,
  output logic [NUM_SRC-1:0]  reqQ,
  output logic [NUM_SRC-1:0]  enQ,
  output logic                globalEnQ,
  output logic [PRIO_W-1:0]   prioQ,
  output logic [NUM_SRC-1:0]  evtVec,
  output logic [DATA_W-1:0]   regRdData
);

  logic [NUM_PINS-1:0] pinVec;
  logic [SYNC_STAGES-1:0][NUM_PINS-1:0] syncQ;
  logic [NUM_PINS-1:0] syncOut;
  logic [NUM_PINS-1:0] prevQ;
  logic [NUM_PINS-1:0] fallEvt;
  logic [NUM_PINS-1:0] riseEvt;

  assign pinVec = {pinC, pinB, pinA};

  // synchronizer chain, idle-high reset so a quiet pin raises nothing
  genvar s;
  generate
    for (s = 0; s < SYNC_STAGES; s++) begin : gSync
      if (s == 0) begin : gFirst
        always_ff @(posedge clk) begin
          if (!rstN) syncQ[s] <= '1;
          else       syncQ[s] <= pinVec;
        end
      end else begin : gRest
        always_ff @(posedge clk) begin
          if (!rstN) syncQ[s] <= '1;
          else       syncQ[s] <= syncQ[s-1];
        end
      end
    end
  endgenerate

  assign syncOut = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rstN) prevQ <= '1;
    else       prevQ <= syncOut;
  end

  assign fallEvt = prevQ & ~syncOut;
  assign riseEvt = ~prevQ & syncOut;

  // source to request-bit mapping
  assign evtVec = {tmr1Pulse, tmr0Pulse, riseEvt[0], fallEvt[2], fallEvt[1], fallEvt[0]};

  logic wrReq, wrMask, wrPrio;
  logic [NUM_SRC-1:0] swKeep;

  assign wrReq  = regWrEn && (regAddr == ADDR_REQ);
  assign wrMask = regWrEn && (regAddr == ADDR_MASK);
  assign wrPrio = regWrEn && (regAddr == ADDR_PRIO);
  assign swKeep = wrReq ? regWrData[NUM_SRC-1:0] : '1;

  // new events win over any clear in the same cycle
  always_ff @(posedge clk) begin
    if (!rstN) reqQ <= '0;
    else       reqQ <= (reqQ & swKeep & ~strobes.clrReq) | evtVec;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enQ       <= '0;
      globalEnQ <= 1'b0;
    end else begin
      if (wrMask) enQ <= regWrData[NUM_SRC-1:0];
      if (strobes.clrGlobal) globalEnQ <= 1'b0;
      else if (wrMask)       globalEnQ <= regWrData[DATA_W-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)      prioQ <= '0;
    else if (wrPrio) prioQ <= regWrData[PRIO_W-1:0];
  end

  always_comb begin
    regRdData = '0;
    case (regAddr)
      ADDR_REQ:  regRdData[NUM_SRC-1:0] = reqQ;
      ADDR_MASK: begin
        regRdData[NUM_SRC-1:0] = enQ;
        regRdData[DATA_W-1]    = globalEnQ;
      end
      ADDR_PRIO: regRdData[PRIO_W-1:0] = prioQ;
      default:   regRdData = '0;
    endcase
  end

endmodule

// File: rtl/irqvc_control.sv
module irqvc_control
  import irqvc_pkg::*;
(
  input  logic [NUM_SRC-1:0] reqQ,
  input  logic [NUM_SRC-1:0] enQ,
  input  logic               globalEnQ,
  input  logic [PRIO_W-1:0]  prioQ,
  input  logic               grant,
  output logic               irqPending,
  output logic [VEC_W-1:0]   vectorAddr,
  output ctrl_strobe_t       strobes
);

  logic [NUM_SRC-1:0] armed;
  logic [IDX_W-1:0]   winIdx;
  logic               found;
  int unsigned        startIdx;
  int unsigned        scanIdx;

  assign armed = reqQ & enQ & {NUM_SRC{globalEnQ}};

  // rotated scan starting at the programmed source
  always_comb begin
    startIdx = (int'(prioQ) < NUM_SRC) ? int'(prioQ) : 0;
    found    = 1'b0;
    winIdx   = '0;
    scanIdx  = 0;
    for (int i = 0; i < NUM_SRC; i++) begin
      scanIdx = (startIdx + i) % NUM_SRC;
      if (!found && armed[scanIdx]) begin
        found  = 1'b1;
        winIdx = IDX_W'(scanIdx);
      end
    end
  end

  assign irqPending = found;
  assign vectorAddr = found ? {winIdx, 1'b0} : '0;

  logic takeIt;
  assign takeIt = grant && found;

  genvar g;
  generate
    for (g = 0; g < NUM_SRC; g++) begin : gClr
      assign strobes.clrReq[g] = takeIt && (winIdx == IDX_W'(g));
    end
  endgenerate

  assign strobes.clrGlobal = takeIt;

endmodule

// File: rtl/irqvc_top.sv
module irqvc_top
  import irqvc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pinA,
  input  logic              pinB,
  input  logic              pinC,
  input  logic              tmr0Pulse,
  input  logic              tmr1Pulse,
  input  logic              regWrEn,
  input  logic [1:0]        regAddr,
  input  logic [7:0]        regWrData,
  output logic [7:0]        regRdData,
  input  logic              grant,
  output logic              irqPending,
  output logic [3:0]        vectorAddr
);

  ctrl_strobe_t       strobes;
  logic [NUM_SRC-1:0] reqQ;
  logic [NUM_SRC-1:0] enQ;
  logic               globalEnQ;
  logic [PRIO_W-1:0]  prioQ;
  logic [NUM_SRC-1:0] evtVec;

  irqvc_datapath #(.SYNC_STAGES(SYNC_STAGES)) dp_i (
    .clk(clk), .rstN(rstN),
    .pinA(pinA), .pinB(pinB), .pinC(pinC),
    .tmr0Pulse(tmr0Pulse), .tmr1Pulse(tmr1Pulse),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .strobes(strobes),
    .reqQ(reqQ), .enQ(enQ), .globalEnQ(globalEnQ), .prioQ(prioQ),
    .evtVec(evtVec), .regRdData(regRdData)
  );

  irqvc_control ctl_i (
    .reqQ(reqQ), .enQ(enQ), .globalEnQ(globalEnQ), .prioQ(prioQ),
    .grant(grant),
    .irqPending(irqPending), .vectorAddr(vectorAddr),
    .strobes(strobes)
  );

endmodule

// File: rtl/irqvc_checker.sv
module irqvc_checker (
  input logic       clk,
  input logic       rstN,
  input logic       grant,
  input logic       irqPending,
  input logic [3:0] vectorAddr,
  input logic [5:0] reqQ,
  input logic [5:0] evtVec,
  input logic       globalEnQ
);

  a_r9_grant_drops_global: assert property (@(posedge clk) disable iff (!rstN)
    (grant && irqPending) |=> !globalEnQ);

  a_r6_no_pending_without_global: assert property (@(posedge clk) disable iff (!rstN)
    !globalEnQ |-> !irqPending);

  a_r8_vector_in_table: assert property (@(posedge clk) disable iff (!rstN)
    irqPending |-> (vectorAddr[0] == 1'b0 && vectorAddr <= 4'd10));

  a_r8_winner_is_requested: assert property (@(posedge clk) disable iff (!rstN)
    irqPending |-> reqQ[vectorAddr[3:1]]);

  a_r2_event_latches: assert property (@(posedge clk) disable iff (!rstN)
    (evtVec != 6'd0) |=> ((reqQ & $past(evtVec)) == $past(evtVec)));

  a_r9_grant_clears_winner: assert property (@(posedge clk) disable iff (!rstN)
    (grant && irqPending && !evtVec[vectorAddr[3:1]]) |=> !reqQ[$past(vectorAddr[3:1])]);

  a_r10_event_beats_clear: assert property (@(posedge clk) disable iff (!rstN)
    (grant && irqPending && evtVec[vectorAddr[3:1]]) |=> reqQ[$past(vectorAddr[3:1])]);

endmodule

bind irqvc_top irqvc_checker chk_i (
  .clk(clk), .rstN(rstN), .grant(grant), .irqPending(irqPending),
  .vectorAddr(vectorAddr), .reqQ(reqQ), .evtVec(evtVec), .globalEnQ(globalEnQ)
);

// File: tb/irqvc_top_tb_top.sv
module irqvc_top_tb_top;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pinA = 1'b1, pinB = 1'b1, pinC = 1'b1;
  logic tmr0Pulse = 1'b0, tmr1Pulse = 1'b0;
  logic regWrEn = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic [7:0] regWrData = 8'd0;
  logic [7:0] regRdData;
  logic grant = 1'b0;
  logic irqPending;
  logic [3:0] vectorAddr;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  irqvc_top dut_i (
    .clk(clk), .rstN(rstN), .pinA(pinA), .pinB(pinB), .pinC(pinC),
    .tmr0Pulse(tmr0Pulse), .tmr1Pulse(tmr1Pulse),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .grant(grant),
    .irqPending(irqPending), .vectorAddr(vectorAddr)
  );

  typedef struct {
    string      tag;
    logic [3:0] vec;
  } exp_item_t;

  exp_item_t expQ[$];
  event grantEv;

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic checkReg(input string tag, input logic [1:0] a, input logic [7:0] exp);
    regAddr = a;
    #1;
    check(tag, regRdData, exp);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  // driver: pulses grant and pushes the expected vector when a win is due
  task automatic doGrant(input bit expectWin, input logic [3:0] vec, input string tag,
                         input bit withTmr0);
    exp_item_t it;
    @(negedge clk);
    grant = 1'b1;
    if (withTmr0) tmr0Pulse = 1'b1;
    if (expectWin) begin
      it.tag = tag; it.vec = vec;
      expQ.push_back(it);
    end
    #2 -> grantEv;
    @(negedge clk);
    grant = 1'b0;
    tmr0Pulse = 1'b0;
  endtask

  // monitor: compares the vector the design presents during each grant
  initial begin
    forever begin
      @(grantEv);
      if (irqPending) begin
        if (expQ.size() == 0) begin
          checks++; failures++;
          $display("FAIL R9 unexpected win actual=%0h expected=none", vectorAddr);
        end else begin
          exp_item_t it;
          it = expQ.pop_front();
          check(it.tag, {4'd0, vectorAddr}, {4'd0, it.vec});
        end
      end
    end
  end

  task automatic fallPin(input int which, input logic [7:0] expReq);
    @(negedge clk);
    case (which)
      0: pinA = 1'b0;
      1: pinB = 1'b0;
      default: pinC = 1'b0;
    endcase
    waitN(3);
    checkReg("R2 pin fall", 2'd0, expReq);
  endtask

  initial begin
    waitN(3);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    checkReg("R1 req", 2'd0, 8'h00);
    checkReg("R1 mask", 2'd1, 8'h00);
    checkReg("R1 prio", 2'd2, 8'h00);
    check("R1 pending", {7'd0, irqPending}, 8'd0);
    checkReg("R5 unused", 2'd3, 8'h00);

    // R2 exact latency on pinB
    @(negedge clk);
    pinB = 1'b0;
    @(negedge clk); checkReg("R2 latency e1", 2'd0, 8'h00);
    @(negedge clk); checkReg("R2 latency e2", 2'd0, 8'h00);
    @(negedge clk); checkReg("R2 latency e3", 2'd0, 8'h02);
    check("R4 masked pending", {7'd0, irqPending}, 8'd0);

    fallPin(0, 8'h03);
    fallPin(2, 8'h07);
    @(negedge clk);
    pinA = 1'b1;
    waitN(3);
    checkReg("R2 pinA rise", 2'd0, 8'h0F);
    @(negedge clk); tmr0Pulse = 1'b1;
    @(negedge clk); tmr0Pulse = 1'b0;
    checkReg("R2 tmr0", 2'd0, 8'h1F);
    @(negedge clk); tmr1Pulse = 1'b1;
    @(negedge clk); tmr1Pulse = 1'b0;
    checkReg("R2 tmr1", 2'd0, 8'h3F);

    waitN(10);
    checkReg("R3 hold R4 poll", 2'd0, 8'h3F);
    wr(2'd0, 8'h3E);
    checkReg("R3 sw clear", 2'd0, 8'h3E);
    wr(2'd0, 8'hFF);
    checkReg("R3 write one no effect", 2'd0, 8'h3E);

    wr(2'd1, 8'h3F);
    check("R6 no global", {7'd0, irqPending}, 8'd0);
    wr(2'd1, 8'hFF);
    checkReg("R5 mask bit6 reads 0", 2'd1, 8'hBF);
    check("R6 armed", {7'd0, irqPending}, 8'd1);

    check("R7 prio0", {4'd0, vectorAddr}, 8'd2);
    wr(2'd2, 8'd4); #1 check("R7 prio4", {4'd0, vectorAddr}, 8'd8);
    wr(2'd2, 8'd6); #1 check("R7 prio6 as 0", {4'd0, vectorAddr}, 8'd2);
    wr(2'd2, 8'd7); #1 check("R7 prio7 as 0", {4'd0, vectorAddr}, 8'd2);
    checkReg("R5 prio read", 2'd2, 8'h07);
    wr(2'd2, 8'd2); #1 check("R7 prio2", {4'd0, vectorAddr}, 8'd4);
    wr(2'd2, 8'd5); #1 check("R8 prio5", {4'd0, vectorAddr}, 8'd10);

    doGrant(1'b1, 4'd10, "R8 R9 grant vec", 1'b0);
    checkReg("R9 req cleared", 2'd0, 8'h1E);
    checkReg("R9 global cleared", 2'd1, 8'h3F);
    check("R9 pending off", {7'd0, irqPending}, 8'd0);

    wr(2'd1, 8'hBF);
    doGrant(1'b1, 4'd2, "R7 R8 wrap grant", 1'b0);
    checkReg("R9 req after 2nd", 2'd0, 8'h1C);

    waitN(6);
    checkReg("R11 held pin no retrigger", 2'd0, 8'h1C);

    wr(2'd1, 8'h82);
    check("R6 own enable clear", {7'd0, irqPending}, 8'd0);

    wr(2'd1, 8'h90);
    wr(2'd2, 8'd0);
    check("R6 single enable", {7'd0, irqPending}, 8'd1);
    check("R8 single vec", {4'd0, vectorAddr}, 8'd8);
    doGrant(1'b1, 4'd8, "R10 collide grant", 1'b1);
    checkReg("R10 event kept", 2'd0, 8'h1C);
    checkReg("R10 global off", 2'd1, 8'h10);

    doGrant(1'b0, 4'd0, "R9 idle grant", 1'b0);
    checkReg("R9 idle req", 2'd0, 8'h1C);
    checkReg("R9 idle mask", 2'd1, 8'h10);
    check("R8 idle vec", {4'd0, vectorAddr}, 8'd0);

    check("R9 all grants seen", 8'(expQ.size()), 8'd0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule